// File: doc/BRIEF.md
# Configuration Address and Data Port Decoder

This block sits on a host-side I/O port bus and turns the classic "write an address word, then touch a data window" configuration mechanism into discrete read and write requests for a downstream configuration fabric. Software first stores a 32-bit address word at the base port. That word holds an enable flag, a bus number, a device, a function and a register number that reaches up to 4095 bytes. Software then reads or writes one, two or four bytes through a data window of four ports just above the address word. The block works out the byte enables from the window offset and the access size. It shifts write data onto the right byte lanes, issues one request, and returns the selected lanes of the completion to the I/O side, right-justified.

I/O data is right-justified on `io_wdata` and `io_rsp_rdata`, and `io_size` encodes 0 = one byte, 1 = two bytes, 2 = four bytes (3 is invalid). Accesses the block does not own are answered with `io_rsp_claimed` low, so a surrounding I/O fabric can forward them elsewhere. Each accepted I/O access receives exactly one response pulse. The request side uses a valid/ready handshake. Its completion (`rsp_valid`) may arrive in the same cycle the request is accepted, or any number of cycles later.

Top module: `cfg_addr_decoder`

## Requirements
- R1: A four-byte write to the base port (default 0x0CF8) stores all 32 bits in the address word and is claimed. A four-byte read of the base port is claimed and returns the word unchanged, for example 0x80000000 after writing 0x80000000. Reset makes the word zero.
- R2: One- and two-byte accesses at base+0 to base+3 (a byte write at base+3, for example) are unclaimed, return zero read data and leave the address word unchanged.
- R3: The request fields come from the address word as follows: bus = bits 23:16, device = bits 15:11, function = bits 10:8. The 12-bit register number is {bits 27:24, bits 7:2, 2'b00}.
- R4: Data window accesses at base+4+n produce these byte enables: one byte sets only bit n; two bytes at n = 0 or n = 2 give 4'b0011 or 4'b1100; four bytes at n = 0 give 4'b1111.
- R5: For writes, right-justified `io_wdata` is shifted left by 8*n bits onto `req_wdata`.
- R6: For reads, the completion dword is shifted right by 8*n bits and masked to the access size before it is returned. The response is claimed.
- R7: With address bit 31 clear, data window accesses are unclaimed and issue no request. Reads among them return ones in the low `io_size` bytes and zero above.
- R8: A read whose completion has `rsp_err` set returns ones in the low `io_size` bytes and zero above, and is claimed. A write completing with `rsp_err` returns zero and is claimed.
- R9: `req_type1` is low when the address bus number equals `local_bus` and high otherwise.
- R10: Misaligned data window accesses are unclaimed, issue no request and return zero. These are two bytes at an odd offset, four bytes at a non-zero offset, and size code 3.
- R11: While `req_valid` is high and `req_ready` is low, the request fields hold stable. A completion that arrives in the same cycle as acceptance finishes the access without a lost cycle.
- R12: Each accepted I/O access yields exactly one single-cycle `io_rsp_valid` pulse. `io_ready` stays low from acceptance until that pulse has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| local_bus | input | 8 | Bus number that is decoded as directly attached (type 0) |
| io_valid | input | 1 | I/O access request |
| io_ready | output | 1 | Block can accept an I/O access |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | Access size code: 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Right-justified I/O write data |
| io_rsp_valid | output | 1 | I/O response pulse |
| io_rsp_claimed | output | 1 | Access was handled by this block |
| io_rsp_rdata | output | 32 | Right-justified I/O read data |
| req_valid | output | 1 | Configuration request valid |
| req_ready | input | 1 | Fabric accepts the request |
| req_write | output | 1 | Request is a write |
| req_type1 | output | 1 | Request targets a bus other than the local one |
| req_bus | output | 8 | Bus number |
| req_dev | output | 5 | Device number |
| req_fn | output | 3 | Function number |
| req_reg | output | 12 | Byte address of the dword register |
| req_be | output | 4 | Byte enables |
| req_wdata | output | 32 | Lane-aligned write data |
| rsp_valid | input | 1 | Completion from the fabric |
| rsp_err | input | 1 | No target answered the request |
| rsp_rdata | input | 32 | Completion dword |

## Verification
Request acceptance and completion capture can fall into the same clock edge. In that case the block has to leave the request state straight for the response state and must not wait for a second completion. The bench provokes this with a target model in zero-latency mode, which raises `rsp_valid` combinationally with `req_valid && req_ready`. It also switches to a stalling mode and a delayed-completion mode, so the same byte-lane reads and writes run through every path. In each mode, both the request fields seen at acceptance and the right-justified I/O result are compared with values the bench computes on its own.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    typedef enum logic [1:0] {
        ACC_NONE    = 2'd0,
        ACC_ADDR_WR = 2'd1,
        ACC_ADDR_RD = 2'd2,
        ACC_DATA    = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } fsm_e;

    localparam int unsigned DWORD_W = 32;
    localparam int unsigned LANES   = DWORD_W / 8;

    typedef struct packed {
        fsm_e                state;
        logic [DWORD_W-1:0]  addr;
        logic                pend_write;
        logic [1:0]          pend_off;
        logic [1:0]          pend_size;
        logic [LANES-1:0]    pend_be;
        logic [DWORD_W-1:0]  pend_wdata;
        logic                rsp_claimed;
        logic [DWORD_W-1:0]  rsp_rdata;
    } regs_t;

endpackage

// File: rtl/cfgdec_port_decode.sv
module cfgdec_port_decode
    import cfgdec_pkg::*;
#(
    parameter int unsigned        IO_AW     = 16,
    parameter logic [IO_AW-1:0]   BASE_PORT = 16'h0CF8
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic             io_write,
    input  logic             cfg_en,
    output acc_kind_e        kind,
    output logic             win_read_off
);

    logic       in_blk;
    logic       hi_half;
    logic [1:0] off;
    logic       aligned;

    assign in_blk  = (io_addr[IO_AW-1:3] == BASE_PORT[IO_AW-1:3]);
    assign hi_half = io_addr[2];
    assign off     = io_addr[1:0];

    always_comb begin
        unique case (io_size)
            2'd0:    aligned = 1'b1;
            2'd1:    aligned = ~off[0];
            2'd2:    aligned = (off == 2'd0);
            default: aligned = 1'b0;
        endcase
    end

    always_comb begin
        kind = ACC_NONE;
        if (in_blk && !hi_half && io_size == 2'd2 && off == 2'd0) begin
            kind = io_write ? ACC_ADDR_WR : ACC_ADDR_RD;
        end else if (in_blk && hi_half && aligned && cfg_en) begin
            kind = ACC_DATA;
        end
    end

    assign win_read_off = in_blk && hi_half && aligned && !cfg_en && !io_write;

endmodule

// File: rtl/cfgdec_lane_steer.sv
module cfgdec_lane_steer
    import cfgdec_pkg::*;
(
    input  logic [1:0]         off,
    input  logic [1:0]         size,
    input  logic [DWORD_W-1:0] io_wdata,
    input  logic [DWORD_W-1:0] tgt_rdata,
    output logic [LANES-1:0]   be,
    output logic [DWORD_W-1:0] lane_wdata,
    output logic [DWORD_W-1:0] rd_just,
    output logic [DWORD_W-1:0] ones_mask
);

    logic [2:0] nbytes;
    logic [2:0] lane_end;
    logic [4:0] shamt;

    always_comb begin
        unique case (size)
            2'd0:    nbytes = 3'd1;
            2'd1:    nbytes = 3'd2;
            2'd2:    nbytes = 3'd4;
            default: nbytes = 3'd0;
        endcase
    end

    assign lane_end = {1'b0, off} + nbytes;
    assign shamt    = {off, 3'b000};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be[i]             = (3'(i) >= {1'b0, off}) && (3'(i) < lane_end);
        assign ones_mask[8*i +: 8] = {8{3'(i) < nbytes}};
    end

    assign lane_wdata = io_wdata << shamt;
    assign rd_just    = (tgt_rdata >> shamt) & ones_mask;

endmodule

// File: rtl/cfg_addr_decoder.sv
module cfg_addr_decoder
    import cfgdec_pkg::*;
#(
    parameter int unsigned      IO_AW     = 16,
    parameter logic [IO_AW-1:0] BASE_PORT = 16'h0CF8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        local_bus,
    input  logic              io_valid,
    output logic              io_ready,
    input  logic              io_write,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [1:0]        io_size,
    input  logic [31:0]       io_wdata,
    output logic              io_rsp_valid,
    output logic              io_rsp_claimed,
    output logic [31:0]       io_rsp_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic              req_type1,
    output logic [7:0]        req_bus,
    output logic [4:0]        req_dev,
    output logic [2:0]        req_fn,
    output logic [11:0]       req_reg,
    output logic [3:0]        req_be,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [31:0]       rsp_rdata
);

    localparam int unsigned EN_BIT = DWORD_W - 1;

    regs_t r_q, r_d;

    acc_kind_e          dec_kind;
    logic               win_off;
    logic [1:0]         steer_off;
    logic [1:0]         steer_size;
    logic [LANES-1:0]   st_be;
    logic [DWORD_W-1:0] st_wdata;
    logic [DWORD_W-1:0] st_rd;
    logic [DWORD_W-1:0] st_ones;
    logic               in_idle;

    assign in_idle = (r_q.state == ST_IDLE);

    cfgdec_port_decode #(
        .IO_AW     (IO_AW),
        .BASE_PORT (BASE_PORT)
    ) u_decode (
        .io_addr      (io_addr),
        .io_size      (io_size),
        .io_write     (io_write),
        .cfg_en       (r_q.addr[EN_BIT]),
        .kind         (dec_kind),
        .win_read_off (win_off)
    );

    assign steer_off  = in_idle ? io_addr[1:0] : r_q.pend_off;
    assign steer_size = in_idle ? io_size      : r_q.pend_size;

    cfgdec_lane_steer u_steer (
        .off        (steer_off),
        .size       (steer_size),
        .io_wdata   (io_wdata),
        .tgt_rdata  (rsp_rdata),
        .be         (st_be),
        .lane_wdata (st_wdata),
        .rd_just    (st_rd),
        .ones_mask  (st_ones)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (io_valid) begin
                    r_d.pend_write  = io_write;
                    r_d.pend_off    = io_addr[1:0];
                    r_d.pend_size   = io_size;
                    r_d.rsp_claimed = 1'b0;
                    r_d.rsp_rdata   = '0;
                    unique case (dec_kind)
                        ACC_ADDR_WR: begin
                            r_d.addr        = io_wdata;
                            r_d.rsp_claimed = 1'b1;
                            r_d.state       = ST_RESP;
                        end
                        ACC_ADDR_RD: begin
                            r_d.rsp_rdata   = r_q.addr;
                            r_d.rsp_claimed = 1'b1;
                            r_d.state       = ST_RESP;
                        end
                        ACC_DATA: begin
                            r_d.pend_be    = st_be;
                            r_d.pend_wdata = st_wdata;
                            r_d.state      = ST_REQ;
                        end
                        default: begin
                            r_d.rsp_rdata = win_off ? st_ones : '0;
                            r_d.state     = ST_RESP;
                        end
                    endcase
                end
            end
            ST_REQ, ST_WAIT: begin
                if (r_q.state == ST_REQ && req_ready && !rsp_valid) begin
                    r_d.state = ST_WAIT;
                end
                if ((r_q.state == ST_WAIT || req_ready) && rsp_valid) begin
                    r_d.rsp_claimed = 1'b1;
                    r_d.rsp_rdata   = r_q.pend_write ? '0 : (rsp_err ? st_ones : st_rd);
                    r_d.state       = ST_RESP;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign io_ready       = in_idle;
    assign io_rsp_valid   = (r_q.state == ST_RESP);
    assign io_rsp_claimed = r_q.rsp_claimed;
    assign io_rsp_rdata   = r_q.rsp_rdata;

    assign req_valid = (r_q.state == ST_REQ);
    assign req_write = r_q.pend_write;
    assign req_bus   = r_q.addr[23:16];
    assign req_dev   = r_q.addr[15:11];
    assign req_fn    = r_q.addr[10:8];
    assign req_reg   = {r_q.addr[27:24], r_q.addr[7:2], 2'b00};
    assign req_be    = r_q.pend_be;
    assign req_wdata = r_q.pend_wdata;
    assign req_type1 = (r_q.addr[23:16] != local_bus);

    // R1
    addr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready && dec_kind == ACC_ADDR_WR) |=> (r_q.addr == $past(io_wdata)));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready && dec_kind != ACC_ADDR_WR) |=> $stable(r_q.addr));

    // R4
    be_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_be != 4'b0000));

    // R7
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> r_q.addr[EN_BIT]);

    // R11
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_be) && $stable(req_reg)
                                       && $stable(req_wdata) && $stable(req_write)));

    // R12
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rsp_valid |=> !io_rsp_valid);

    // R12
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_ready) |=> !io_ready);

    // R12
    rsp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rsp_valid |-> !io_ready);

endmodule

// File: tb/tb_cfg_addr_decoder.sv
module tb_cfg_addr_decoder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  local_bus = 8'h00;
    logic        io_valid = 1'b0;
    logic        io_ready;
    logic        io_write = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [1:0]  io_size = 2'd0;
    logic [31:0] io_wdata = 32'h0;
    logic        io_rsp_valid;
    logic        io_rsp_claimed;
    logic [31:0] io_rsp_rdata;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic        req_write;
    logic        req_type1;
    logic [7:0]  req_bus;
    logic [4:0]  req_dev;
    logic [2:0]  req_fn;
    logic [11:0] req_reg;
    logic [3:0]  req_be;
    logic [31:0] req_wdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [31:0] rsp_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_addr_decoder dut (
        .clk(clk), .rst_n(rst_n), .local_bus(local_bus),
        .io_valid(io_valid), .io_ready(io_ready), .io_write(io_write),
        .io_addr(io_addr), .io_size(io_size), .io_wdata(io_wdata),
        .io_rsp_valid(io_rsp_valid), .io_rsp_claimed(io_rsp_claimed),
        .io_rsp_rdata(io_rsp_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_type1(req_type1), .req_bus(req_bus), .req_dev(req_dev),
        .req_fn(req_fn), .req_reg(req_reg), .req_be(req_be),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    int n_vec = 0;
    int n_err = 0;

    typedef struct {
        string       tag;
        logic        claimed;
        logic [31:0] rdata;
    } exp_io_t;

    typedef struct {
        string       tag;
        logic        wr;
        logic        t1;
        logic [7:0]  bus;
        logic [4:0]  dev;
        logic [2:0]  fn;
        logic [11:0] rg;
        logic [3:0]  be;
        logic [31:0] wd;
    } exp_req_t;

    exp_io_t  io_q[$];
    exp_req_t req_q[$];
    logic [31:0] mem [int];

    logic [31:0] sh_addr = 32'h0;
    logic        tgt_zero = 1'b0;
    logic        tgt_stall = 1'b0;
    logic        tgt_absent = 1'b0;
    logic        dly_valid = 1'b0;
    logic [31:0] dly_data = 32'h0;
    logic [31:0] zero_data = 32'h0;
    int          dly_cnt = 0;
    int          stall_cnt = 0;

    function automatic int mkey(input logic [7:0] b, input logic [4:0] d,
                                input logic [2:0] f, input logic [11:0] r);
        return int'({b, d, f, r[11:2]});
    endfunction

    function automatic logic [31:0] mem_rd(input int k);
        if (mem.exists(k)) return mem[k];
        return 32'h0;
    endfunction

    assign rsp_valid = tgt_zero ? (req_valid && req_ready) : dly_valid;
    assign rsp_rdata = tgt_zero ? zero_data : dly_data;
    assign rsp_err   = tgt_absent;

    // Target model and request monitor, all at the falling edge
    always @(negedge clk) begin
        if (dly_valid) dly_valid = 1'b0;
        if (dly_cnt != 0) begin
            dly_cnt = dly_cnt - 1;
            if (dly_cnt == 0) dly_valid = 1'b1;
        end
        stall_cnt = (stall_cnt + 1) % 3;
        req_ready = tgt_stall ? (stall_cnt == 0) : 1'b1;
        if (rst_n && req_valid) begin
            zero_data = mem_rd(mkey(req_bus, req_dev, req_fn, req_reg));
            if (req_ready) begin
                n_vec++;
                if (req_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R7/R10 unexpected request: act bus=%h reg=%h be=%h exp none",
                             req_bus, req_reg, req_be);
                end else begin
                    exp_req_t e;
                    e = req_q.pop_front();
                    if (req_write !== e.wr || req_type1 !== e.t1 || req_bus !== e.bus ||
                        req_dev !== e.dev || req_fn !== e.fn || req_reg !== e.rg ||
                        req_be !== e.be || (e.wr && req_wdata !== e.wd)) begin
                        n_err++;
                        $display("FAIL %s req: act wr=%b t1=%b bus=%h dev=%h fn=%h reg=%h be=%h wd=%h exp wr=%b t1=%b bus=%h dev=%h fn=%h reg=%h be=%h wd=%h",
                                 e.tag, req_write, req_type1, req_bus, req_dev, req_fn, req_reg,
                                 req_be, req_wdata, e.wr, e.t1, e.bus, e.dev, e.fn, e.rg, e.be, e.wd);
                    end
                end
                if (req_write && !tgt_absent) begin
                    int k;
                    logic [31:0] v;
                    k = mkey(req_bus, req_dev, req_fn, req_reg);
                    v = mem_rd(k);
                    for (int i = 0; i < 4; i++)
                        if (req_be[i]) v[8*i +: 8] = req_wdata[8*i +: 8];
                    mem[k] = v;
                end
                if (!tgt_zero) begin
                    dly_data = zero_data;
                    dly_cnt  = 2;
                end
            end
        end
    end

    // I/O response monitor
    always @(negedge clk) begin
        if (rst_n && io_rsp_valid) begin
            n_vec++;
            if (io_q.size() == 0) begin
                n_err++;
                $display("FAIL R12 unexpected io response: act claimed=%b rdata=%h exp none",
                         io_rsp_claimed, io_rsp_rdata);
            end else begin
                exp_io_t e;
                e = io_q.pop_front();
                if (io_rsp_claimed !== e.claimed || io_rsp_rdata !== e.rdata) begin
                    n_err++;
                    $display("FAIL %s io: act claimed=%b rdata=%h exp claimed=%b rdata=%h",
                             e.tag, io_rsp_claimed, io_rsp_rdata, e.claimed, e.rdata);
                end
            end
        end
    end

    task automatic io_acc(input string tag, input logic wr, input logic [15:0] a,
                          input logic [1:0] sz, input logic [31:0] wd,
                          input logic exp_cl, input logic [31:0] exp_rd);
        exp_io_t e;
        e.tag = tag; e.claimed = exp_cl; e.rdata = exp_rd;
        io_q.push_back(e);
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
        while (!io_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        io_valid = 1'b0;
        while (io_q.size() != 0 || req_q.size() != 0) @(negedge clk);
    endtask

    function automatic logic [31:0] low_ones(input logic [1:0] sz);
        case (sz)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    task automatic set_addr(input string tag, input logic [31:0] v);
        io_acc(tag, 1'b1, 16'h0CF8, 2'd2, v, 1'b1, 32'h0);
        sh_addr = v;
    endtask

    // Enabled data-window access with bench-computed expectations
    task automatic cfg_acc(input string tag, input logic wr, input logic [1:0] off,
                           input logic [1:0] sz, input logic [31:0] wd);
        exp_req_t r;
        logic [31:0] cur;
        logic [31:0] exp_rd;
        int nb;
        nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
        r.tag = tag; r.wr = wr;
        r.bus = sh_addr[23:16];
        r.dev = sh_addr[15:11];
        r.fn  = sh_addr[10:8];
        r.rg  = {sh_addr[27:24], sh_addr[7:2], 2'b00};
        r.t1  = (sh_addr[23:16] != local_bus);
        r.be  = 4'b0;
        r.wd  = 32'h0;
        for (int i = 0; i < nb; i++) begin
            r.be[off + i] = 1'b1;
            r.wd[8*(off+i) +: 8] = wd[8*i +: 8];
        end
        req_q.push_back(r);
        cur = mem_rd(mkey(r.bus, r.dev, r.fn, r.rg));
        exp_rd = 32'h0;
        if (!wr) begin
            if (tgt_absent) exp_rd = low_ones(sz);
            else for (int i = 0; i < nb; i++) exp_rd[8*i +: 8] = cur[8*(off+i) +: 8];
        end
        io_acc(tag, wr, 16'h0CFC + 16'(off), sz, wd, 1'b1, exp_rd);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        n_err++;
        $display("FAIL watchdog expired: act running exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        mem[mkey(8'h05, 5'd11, 3'd2, 12'h33C)] = 32'h4433_2211;
        mem[mkey(8'h00, 5'd1, 3'd0, 12'h000)]  = 32'hCAFE_F00D;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value
        io_acc("R1 reset readback", 1'b0, 16'h0CF8, 2'd2, 0, 1'b1, 32'h0);

        // R7 enable clear
        io_acc("R7 dword read disabled", 1'b0, 16'h0CFC, 2'd2, 0, 1'b0, 32'hFFFF_FFFF);
        io_acc("R7 byte read disabled", 1'b0, 16'h0CFE, 2'd0, 0, 1'b0, 32'h0000_00FF);
        io_acc("R7 word write disabled", 1'b1, 16'h0CFE, 2'd1, 32'h1234, 1'b0, 32'h0);

        // R1 write and readback
        set_addr("R1 write enable word", 32'h8000_0000);
        io_acc("R1 readback", 1'b0, 16'h0CF8, 2'd2, 0, 1'b1, 32'h8000_0000);

        // R2 narrow accesses to the address ports
        io_acc("R2 byte write base+3", 1'b1, 16'h0CFB, 2'd0, 32'h01, 1'b0, 32'h0);
        io_acc("R2 readback after byte write", 1'b0, 16'h0CF8, 2'd2, 0, 1'b1, 32'h8000_0000);
        io_acc("R2 word read base+2", 1'b0, 16'h0CFA, 2'd1, 0, 1'b0, 32'h0);

        // R3 R9 extended register bits, remote bus
        set_addr("R3 set address", 32'h8305_5A3C);
        io_acc("R1 readback ext", 1'b0, 16'h0CF8, 2'd2, 0, 1'b1, 32'h8305_5A3C);
        cfg_acc("R3 R6 R9 dword read", 1'b0, 2'd0, 2'd2, 0);
        for (int n = 0; n < 4; n++) cfg_acc("R4 R6 byte read", 1'b0, 2'(n), 2'd0, 0);
        cfg_acc("R4 R6 word read hi", 1'b0, 2'd2, 2'd1, 0);
        cfg_acc("R4 R6 word read lo", 1'b0, 2'd0, 2'd1, 0);

        // R5 writes
        cfg_acc("R5 byte write lane1", 1'b1, 2'd1, 2'd0, 32'h0000_00AB);
        cfg_acc("R5 word write lane2", 1'b1, 2'd2, 2'd1, 32'h0000_BEEF);
        cfg_acc("R5 R6 readback", 1'b0, 2'd0, 2'd2, 0);
        cfg_acc("R5 byte write lane3", 1'b1, 2'd3, 2'd0, 32'h0000_005A);
        cfg_acc("R5 readback lane3", 1'b0, 2'd3, 2'd0, 0);

        // R9 local bus
        local_bus = 8'h05;
        cfg_acc("R9 type0 dword write", 1'b1, 2'd0, 2'd2, 32'h1234_5678);
        cfg_acc("R9 type0 read", 1'b0, 2'd0, 2'd2, 0);

        // R11 same-cycle completion
        tgt_zero = 1'b1;
        cfg_acc("R11 zero-latency read", 1'b0, 2'd1, 2'd0, 0);
        cfg_acc("R11 zero-latency write", 1'b1, 2'd2, 2'd1, 32'h0000_A5C3);
        cfg_acc("R11 zero-latency readback", 1'b0, 2'd0, 2'd2, 0);

        // R11 stalled acceptance
        tgt_stall = 1'b1;
        cfg_acc("R11 stall zero-latency read", 1'b0, 2'd2, 2'd1, 0);
        tgt_zero = 1'b0;
        cfg_acc("R11 stall delayed write", 1'b1, 2'd0, 2'd2, 32'hDEAD_BEEF);
        cfg_acc("R11 stall delayed read", 1'b0, 2'd0, 2'd2, 0);
        tgt_stall = 1'b0;

        // R10 misaligned
        io_acc("R10 word at odd", 1'b0, 16'h0CFD, 2'd1, 0, 1'b0, 32'h0);
        io_acc("R10 dword at +2", 1'b1, 16'h0CFE, 2'd2, 32'h1, 1'b0, 32'h0);
        io_acc("R10 size code 3", 1'b0, 16'h0CFC, 2'd3, 0, 1'b0, 32'h0);

        // R8 no target
        tgt_absent = 1'b1;
        cfg_acc("R8 absent byte read", 1'b0, 2'd3, 2'd0, 0);
        cfg_acc("R8 absent dword read", 1'b0, 2'd0, 2'd2, 0);
        cfg_acc("R8 absent write", 1'b1, 2'd0, 2'd1, 32'h0000_7777);
        tgt_absent = 1'b0;
        cfg_acc("R8 memory unchanged", 1'b0, 2'd0, 2'd2, 0);

        // R3 R9 different function on another bus
        set_addr("R3 second address", 32'h8000_0800);
        cfg_acc("R3 R9 bus0 type1 read", 1'b0, 2'd0, 2'd2, 0);

        // R7 enable cleared again
        set_addr("R7 clear enable", 32'h0005_5A3C);
        io_acc("R7 word read disabled", 1'b0, 16'h0CFC, 2'd1, 0, 1'b0, 32'h0000_FFFF);
        io_acc("R7 readback disabled word", 1'b0, 16'h0CF8, 2'd2, 0, 1'b1, 32'h0005_5A3C);

        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule